// File: doc/BRIEF.md
# Local Memory Bus Controller

This block runs single read and write cycles on an 8-bit data, 11-bit address local bus for one internal requester. Each access goes to one of three regions: RAM, configuration ROM or a non-volatile counter area. The block asserts the select line for that region for the whole access. A slow device holds an access open by keeping the acknowledge input low. Tying acknowledge high gives the shortest access.

The requester offers an access with a one-cycle `req_valid` pulse while `req_busy` is low. The requester then waits for a one-cycle `rsp_done` pulse. On a read, that pulse comes with the byte taken from the bus.

An external master can claim the bus through an active-low request. The block never breaks into an access it has started. It finishes the access, enters an idle state, gives an active-low grant, and lets every address, data, direction and select output float until the request goes away.

Top module: `lbus_ctrl`

## Requirements
- R1: The address bus is 11 bits and the data bus 8 bits, bit 0 being the LSB. During a write access the block drives `lb_data` with the requested byte. On a read, the byte present on `lb_data` when the access completes is returned on `rsp_rdata`.
- R2: `lb_rd` is 1 during a read access and 0 during a write access. `lb_rd` rests at 1 when no access is running.
- R3: While the synchronized acknowledge is 0, the access is held in wait states. During that time the address, direction and select stay unchanged and no completion is reported.
- R4: `req_region` picks the select line. Code 0 drives `ram_sel_n` low. Code 1 drives `rom_sel_n` low. Codes 2 and 3 drive `nvc_sel` high. At most one select is active at a time, and none is active outside an access.
- R5: With acknowledge held high, the select is active for exactly 2 cycles. `rsp_done` is high for one cycle, in the cycle after the second clock edge that follows the edge which accepted `req_valid`.
- R6: `ext_req_n` and `mem_ack` each pass through a two-flop synchronizer. After `ext_req_n` falls with the block idle, `ext_gnt_n` falls on the third clock edge. The grant is never given during an access. An access in progress completes first, and the grant follows one edge after `rsp_done` rises.
- R7: While `ext_gnt_n` is low, `lb_addr`, `lb_data`, `lb_rd`, `ram_sel_n`, `rom_sel_n` and `nvc_sel` are all high impedance.
- R8: After `ext_req_n` rises, `ext_gnt_n` returns high on the third clock edge.
- R9: `req_busy` is high during an access, while granted, and while a synchronized external request is pending. A `req_valid` pulse given while `req_busy` is high is ignored: it causes no bus access and no `rsp_done`.
- R10: In reset, `ext_gnt_n` is 1, `req_busy` and `rsp_done` are 0, all selects are inactive and `lb_rd` is 1.
- R11: A completion in progress is never pre-empted. If an external request and an internal `req_valid` both arrive at an idle block, the external request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access request pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_region | input | 2 | Region code (0 RAM, 1 ROM, 2/3 counter) |
| req_addr | input | 11 | Access address |
| req_wdata | input | 8 | Write byte |
| req_busy | output | 1 | Block cannot accept a request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte, valid with `rsp_done` on reads |
| mem_ack | input | 1 | Memory acknowledge, 0 inserts wait states, asynchronous |
| ext_req_n | input | 1 | External master bus request, active low, asynchronous |
| ext_gnt_n | output | 1 | Bus grant to external master, active low |
| lb_addr | output | 11 | Local bus address, floats while granted |
| lb_data | inout | 8 | Local bus data |
| lb_rd | output | 1 | Direction, 1 read / 0 write, floats while granted |
| ram_sel_n | output | 1 | RAM select, active low |
| rom_sel_n | output | 1 | ROM select, active low |
| nvc_sel | output | 1 | Counter region select, active high |

## Verification
The bench uses the default parameters: 11-bit address, 8-bit data, two synchronizer stages and a single setup cycle. With these values every latency in the requirements comes to a small fixed count of edges, so the bench can sample each one exactly. A bus model answers reads from three 64-byte windows, one per region, and that gives all four region codes plus write-then-read round trips. The bench also acts as the external master and drives the shared bus nets while granted, which exposes any output that fails to float.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_GRANT  = 2'd3
  } lbc_state_e;

  // region code: bit 1 set means the counter area
  localparam logic [1:0] RGN_RAM = 2'd0;
  localparam logic [1:0] RGN_ROM = 2'd1;

  localparam int NUM_SEL = 3;

endpackage

// File: rtl/lbc_sync.sv
module lbc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = d_i;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/lbc_seq.sv
module lbc_seq
  import lbc_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_region,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ack_s,
  input  logic              breq_s,
  input  logic [DATA_W-1:0] bus_rdata,
  output lbc_state_e        state_o,
  output logic              cyc_write,
  output logic [1:0]        cyc_region,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [DATA_W-1:0] cyc_wdata,
  output logic              granted,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);

  localparam int CNT_W = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETUP_CYC - 1);

  lbc_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              done_q, done_d;
  logic              load_en;
  logic              rdat_en;
  logic              wr_q;
  logic [1:0]        rgn_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q;
  logic [DATA_W-1:0] rdat_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load_en = 1'b0;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (breq_s) begin
          state_d = ST_GRANT;
        end else if (req_valid) begin
          load_en = 1'b1;
          cnt_d   = '0;
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (cnt_q == CNT_LAST) state_d = ST_STROBE;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      ST_STROBE: begin
        if (ack_s) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      ST_GRANT: begin
        if (!breq_s) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign rdat_en = done_d & ~wr_q;

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  // access fields, loaded on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      rgn_q  <= RGN_RAM;
      addr_q <= '0;
      wdat_q <= '0;
    end else if (load_en) begin
      wr_q   <= req_write;
      rgn_q  <= req_region;
      addr_q <= req_addr;
      wdat_q <= req_wdata;
    end
  end

  // read return byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdat_q <= '0;
    else if (rdat_en) rdat_q <= bus_rdata;
  end

  assign state_o    = state_q;
  assign cyc_write  = wr_q;
  assign cyc_region = rgn_q;
  assign cyc_addr   = addr_q;
  assign cyc_wdata  = wdat_q;
  assign granted    = (state_q == ST_GRANT);
  assign busy       = (state_q != ST_IDLE) | breq_s;
  assign done       = done_q;
  assign rdata      = rdat_q;

  // wait states keep the access frozen
  assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STROBE && !ack_s) |=>
      (state_q == ST_STROBE && $stable(addr_q) && $stable(wr_q) && $stable(rgn_q)));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_grant_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(granted) |-> ($past(state_q) == ST_IDLE && $past(breq_s)));

  assert_grant_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (granted && !breq_s) |=> !granted);

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(addr_q));

  assert_ext_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && breq_s && req_valid) |=> granted);

endmodule

// File: rtl/lbc_pins.sv
module lbc_pins
  import lbc_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lbc_state_e        state_i,
  input  logic              cyc_write,
  input  logic [1:0]        cyc_region,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [DATA_W-1:0] cyc_wdata,
  output logic [ADDR_W-1:0] pad_addr,
  output logic              pad_rd,
  output logic              pad_ram_n,
  output logic              pad_rom_n,
  output logic              pad_nvc,
  output logic [DATA_W-1:0] pad_wdata,
  output logic              ctl_oe,
  output logic              data_oe
);

  logic               cyc_active;
  logic [NUM_SEL-1:0] sel_hot;

  assign cyc_active = (state_i == ST_SETUP) || (state_i == ST_STROBE);

  genvar g;
  generate
    for (g = 0; g < NUM_SEL; g++) begin : g_sel
      if (g < NUM_SEL - 1) begin : g_mem
        assign sel_hot[g] = cyc_active && !cyc_region[1] && (cyc_region[0] == g[0]);
      end else begin : g_nvc
        assign sel_hot[g] = cyc_active && cyc_region[1];
      end
    end
  endgenerate

  assign pad_addr  = cyc_active ? cyc_addr : '0;
  assign pad_rd    = cyc_active ? ~cyc_write : 1'b1;
  assign pad_ram_n = ~sel_hot[0];
  assign pad_rom_n = ~sel_hot[1];
  assign pad_nvc   = sel_hot[2];
  assign pad_wdata = cyc_wdata;
  assign ctl_oe    = (state_i != ST_GRANT);
  assign data_oe   = cyc_active && cyc_write;

  assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~pad_ram_n, ~pad_rom_n, pad_nvc}) <= 1);

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_IDLE) |-> (pad_ram_n && pad_rom_n && !pad_nvc && pad_rd));

  assert_float_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_GRANT) |-> (!ctl_oe && !data_oe));

endmodule

// File: rtl/lbus_ctrl.sv
module lbus_ctrl
  import lbc_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SETUP_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_region,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_busy,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              mem_ack,
  input  logic              ext_req_n,
  output logic              ext_gnt_n,
  output logic [ADDR_W-1:0] lb_addr,
  inout  wire  [DATA_W-1:0] lb_data,
  output logic              lb_rd,
  output logic              ram_sel_n,
  output logic              rom_sel_n,
  output logic              nvc_sel
);

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              ack_s;
  logic              breq_n_s;
  lbc_state_e        state;
  logic              cyc_write;
  logic [1:0]        cyc_region;
  logic [ADDR_W-1:0] cyc_addr;
  logic [DATA_W-1:0] cyc_wdata;
  logic              granted;
  logic [ADDR_W-1:0] pad_addr;
  logic              pad_rd;
  logic              pad_ram_n;
  logic              pad_rom_n;
  logic              pad_nvc;
  logic [DATA_W-1:0] pad_wdata;
  logic              ctl_oe;
  logic              data_oe;

  // reset: asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  lbc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(mem_ack), .q_o(ack_s)
  );

  lbc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_breq_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(ext_req_n), .q_o(breq_n_s)
  );

  lbc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_region (req_region),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .ack_s      (ack_s),
    .breq_s     (~breq_n_s),
    .bus_rdata  (lb_data),
    .state_o    (state),
    .cyc_write  (cyc_write),
    .cyc_region (cyc_region),
    .cyc_addr   (cyc_addr),
    .cyc_wdata  (cyc_wdata),
    .granted    (granted),
    .busy       (req_busy),
    .done       (rsp_done),
    .rdata      (rsp_rdata)
  );

  lbc_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .state_i    (state),
    .cyc_write  (cyc_write),
    .cyc_region (cyc_region),
    .cyc_addr   (cyc_addr),
    .cyc_wdata  (cyc_wdata),
    .pad_addr   (pad_addr),
    .pad_rd     (pad_rd),
    .pad_ram_n  (pad_ram_n),
    .pad_rom_n  (pad_rom_n),
    .pad_nvc    (pad_nvc),
    .pad_wdata  (pad_wdata),
    .ctl_oe     (ctl_oe),
    .data_oe    (data_oe)
  );

  assign ext_gnt_n = ~granted;
  assign lb_addr   = ctl_oe  ? pad_addr  : 'z;
  assign lb_rd     = ctl_oe  ? pad_rd    : 1'bz;
  assign ram_sel_n = ctl_oe  ? pad_ram_n : 1'bz;
  assign rom_sel_n = ctl_oe  ? pad_rom_n : 1'bz;
  assign nvc_sel   = ctl_oe  ? pad_nvc   : 1'bz;
  assign lb_data   = data_oe ? pad_wdata : 'z;

endmodule

// File: tb/lbus_ctrl_tb_top.sv
module lbus_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [1:0]  req_region;
  logic [10:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_busy;
  logic        rsp_done;
  logic [7:0]  rsp_rdata;
  logic        mem_ack;
  logic        ext_req_n;
  logic        ext_gnt_n;
  wire  [10:0] lb_addr;
  wire  [7:0]  lb_data;
  wire         lb_rd;
  wire         ram_sel_n;
  wire         rom_sel_n;
  wire         nvc_sel;

  // external master model
  logic        ext_drv;
  localparam logic [10:0] EXT_ADDR = 11'h2A5;
  localparam logic [7:0]  EXT_DATA = 8'hC3;

  // bus memory model: three 64-byte windows
  logic [7:0] mem [3][64];
  logic [7:0] ref_mem [3][64];
  logic       sel_any;
  int         rgn_idx;
  logic       mem_rd_en;

  int n_tests = 0;
  int n_fail  = 0;
  int sel_cycles = 0;

  typedef struct {
    bit         wr;
    logic [7:0] data;
  } exp_t;
  exp_t exp_q[$];

  // access under way, for the bus monitor
  bit          cur_on = 0;
  bit          cur_wr;
  logic [1:0]  cur_rgn;
  logic [10:0] cur_addr;
  logic [7:0]  cur_wdata;

  lbus_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_region(req_region),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_busy(req_busy), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_ack(mem_ack), .ext_req_n(ext_req_n), .ext_gnt_n(ext_gnt_n),
    .lb_addr(lb_addr), .lb_data(lb_data), .lb_rd(lb_rd),
    .ram_sel_n(ram_sel_n), .rom_sel_n(rom_sel_n), .nvc_sel(nvc_sel)
  );

  assign sel_any   = (ram_sel_n == 1'b0) || (rom_sel_n == 1'b0) || (nvc_sel == 1'b1);
  assign rgn_idx   = (ram_sel_n == 1'b0) ? 0 : ((rom_sel_n == 1'b0) ? 1 : 2);
  assign mem_rd_en = !ext_drv && ext_gnt_n && sel_any && (lb_rd == 1'b1);

  assign lb_addr   = ext_drv ? EXT_ADDR : 'z;
  assign lb_rd     = ext_drv ? 1'b0 : 1'bz;
  assign ram_sel_n = ext_drv ? 1'b1 : 1'bz;
  assign rom_sel_n = ext_drv ? 1'b1 : 1'bz;
  assign nvc_sel   = ext_drv ? 1'b0 : 1'bz;
  assign lb_data   = ext_drv ? EXT_DATA : (mem_rd_en ? mem[rgn_idx][lb_addr[5:0]] : 'z);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int ridx(input logic [1:0] r);
    return r[1] ? 2 : int'(r);
  endfunction

  // bus monitor and write capture
  always @(negedge clk) begin
    if (rst_n && ext_gnt_n && !ext_drv && sel_any) begin
      sel_cycles++;
      if (cur_on) begin
        chk(lb_addr == cur_addr, "R1", "address on bus", int'(lb_addr), int'(cur_addr));
        chk(lb_rd == !cur_wr, "R2", "direction", int'(lb_rd), int'(!cur_wr));
        chk(rgn_idx == ridx(cur_rgn), "R4", "select line", rgn_idx, ridx(cur_rgn));
        if (cur_wr)
          chk(lb_data == cur_wdata, "R1", "write data", int'(lb_data), int'(cur_wdata));
      end else begin
        chk(1'b0, "R9", "bus access without request", 1, 0);
      end
      if (lb_rd == 1'b0) mem[rgn_idx][lb_addr[5:0]] = lb_data;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9", "unexpected completion", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (!e.wr)
          chk(rsp_rdata == e.data, "R1", "read data", int'(rsp_rdata), int'(e.data));
      end
    end
  end

  task automatic start_req(input bit wr, input logic [1:0] rgn,
                           input logic [10:0] a, input logic [7:0] d);
    exp_t e;
    while (req_busy) @(negedge clk);
    e.wr   = wr;
    e.data = ref_mem[ridx(rgn)][a[5:0]];
    if (wr) ref_mem[ridx(rgn)][a[5:0]] = d;
    exp_q.push_back(e);
    cur_on = 1; cur_wr = wr; cur_rgn = rgn; cur_addr = a; cur_wdata = d;
    sel_cycles = 0;
    req_valid = 1'b1; req_write = wr; req_region = rgn; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!rsp_done && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic access(input bit wr, input logic [1:0] rgn,
                        input logic [10:0] a, input logic [7:0] d, input bit tchk);
    int n;
    start_req(wr, rgn, a, d);
    wait_done(n);
    if (tchk) begin
      chk(n == 2, "R5", "edges to completion", n, 2);
      chk(sel_cycles == 2, "R5", "select cycles", sel_cycles, 2);
    end
    @(negedge clk);
    chk(rsp_done == 1'b0, "R5", "done single cycle", int'(rsp_done), 0);
    cur_on = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int n;
    for (int r = 0; r < 3; r++)
      for (int i = 0; i < 64; i++) begin
        mem[r][i]     = 8'((r * 64 + i) * 37 + 11);
        ref_mem[r][i] = 8'((r * 64 + i) * 37 + 11);
      end
    ext_drv = 1'b0; rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_region = 2'd0; req_addr = '0; req_wdata = '0; mem_ack = 1'b1; ext_req_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(ext_gnt_n == 1'b1, "R10", "grant in reset", int'(ext_gnt_n), 1);
    chk(req_busy == 1'b0, "R10", "busy in reset", int'(req_busy), 0);
    chk(rsp_done == 1'b0, "R10", "done in reset", int'(rsp_done), 0);
    chk(!sel_any, "R10", "selects in reset", int'(sel_any), 0);
    chk(lb_rd == 1'b1, "R10", "direction in reset", int'(lb_rd), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 R4 R5: writes then reads to all region codes
    access(1'b1, 2'd0, 11'h405, 8'hA5, 1'b1);
    access(1'b1, 2'd1, 11'h013, 8'h3C, 1'b1);
    access(1'b1, 2'd2, 11'h021, 8'h5F, 1'b1);
    access(1'b1, 2'd3, 11'h7E2, 8'h81, 1'b1);
    chk(mem[0][5] == 8'hA5, "R1", "RAM captured byte", int'(mem[0][5]), 8'hA5);
    chk(mem[2][34] == 8'h81, "R4", "code 3 reaches counter area", int'(mem[2][34]), 8'h81);
    access(1'b0, 2'd0, 11'h405, 8'h00, 1'b1);
    access(1'b0, 2'd1, 11'h013, 8'h00, 1'b1);
    access(1'b0, 2'd2, 11'h021, 8'h00, 1'b1);
    access(1'b0, 2'd3, 11'h022, 8'h00, 1'b1);
    access(1'b0, 2'd1, 11'h03F, 8'h00, 1'b1);

    // R3: wait states through acknowledge
    mem_ack = 1'b0;
    repeat (3) @(negedge clk);
    start_req(1'b0, 2'd1, 11'h10A, 8'h00);
    repeat (6) @(negedge clk);
    chk(rsp_done == 1'b0, "R3", "no completion while ack low", int'(rsp_done), 0);
    chk(req_busy == 1'b1, "R3", "busy while waiting", int'(req_busy), 1);
    chk(rom_sel_n == 1'b0, "R3", "select held in wait", int'(rom_sel_n), 0);
    mem_ack = 1'b1;
    wait_done(n);
    chk(n == 3, "R3", "edges from ack to completion", n, 3);
    @(negedge clk);
    cur_on = 0;

    // R6 R7 R8 R9: grant from idle
    ext_req_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(ext_gnt_n == 1'b1, "R6", "grant not before third edge", int'(ext_gnt_n), 1);
    @(negedge clk);
    chk(ext_gnt_n == 1'b0, "R6", "grant on third edge", int'(ext_gnt_n), 0);
    chk(req_busy == 1'b1, "R9", "busy while granted", int'(req_busy), 1);
    ext_drv = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_region = 2'd0; req_addr = 11'h001; req_wdata = 8'hEE;
    @(negedge clk);
    req_valid = 1'b0;
    chk(lb_addr == EXT_ADDR, "R7", "address floats", int'(lb_addr), int'(EXT_ADDR));
    chk(lb_data == EXT_DATA, "R7", "data floats", int'(lb_data), int'(EXT_DATA));
    chk(lb_rd == 1'b0, "R7", "direction floats", int'(lb_rd), 0);
    chk(ram_sel_n && rom_sel_n && !nvc_sel, "R7", "selects float", int'(sel_any), 0);
    ext_drv = 1'b0;
    ext_req_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ext_gnt_n == 1'b0, "R8", "grant held two edges", int'(ext_gnt_n), 0);
    @(negedge clk);
    chk(ext_gnt_n == 1'b1, "R8", "grant removed third edge", int'(ext_gnt_n), 1);
    sel_cycles = 0;
    repeat (6) @(negedge clk);
    chk(sel_cycles == 0, "R9", "request during grant ignored", sel_cycles, 0);
    chk(mem[0][1] != 8'hEE, "R9", "no write from ignored request", int'(mem[0][1]), int'(ref_mem[0][1]));

    // R6: request during an access waits for it
    mem_ack = 1'b0;
    repeat (3) @(negedge clk);
    start_req(1'b0, 2'd0, 11'h405, 8'h00);
    @(negedge clk);
    ext_req_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(ext_gnt_n == 1'b1, "R6", "no grant mid access", int'(ext_gnt_n), 1);
    mem_ack = 1'b1;
    wait_done(n);
    chk(ext_gnt_n == 1'b1, "R6", "no grant at completion", int'(ext_gnt_n), 1);
    @(negedge clk);
    cur_on = 0;
    chk(ext_gnt_n == 1'b0, "R6", "grant after completion", int'(ext_gnt_n), 0);
    ext_req_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: external request and internal request together at idle
    ext_req_n = 1'b0;
    repeat (2) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_region = 2'd1; req_addr = 11'h002;
    @(negedge clk);
    req_valid = 1'b0;
    chk(ext_gnt_n == 1'b0, "R11", "external request wins", int'(ext_gnt_n), 0);
    ext_req_n = 1'b1;
    sel_cycles = 0;
    repeat (6) @(negedge clk);
    chk(sel_cycles == 0, "R11", "losing request dropped", sel_cycles, 0);

    // final round trip after arbitration
    access(1'b1, 2'd2, 11'h030, 8'h77, 1'b1);
    access(1'b0, 2'd2, 11'h030, 8'h00, 1'b1);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "all completions seen", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule